// File: doc/BRIEF.md
# Transmit descriptor ring fetcher

This block walks a circular list of 16-byte transmit descriptors kept in system memory. Software sets the ring's base address and its size in bytes, then moves the tail index forward to hand over work. While the head index differs from the tail, the engine reads the descriptor at the head, passes its buffer address, length and command byte to a packet streamer, and optionally marks the descriptor done in memory. It then steps the head forward, wrapping at the end of the ring.

Each descriptor is little-endian. Bytes 0-7 hold the buffer address, bytes 8-9 the length, byte 11 the command byte and byte 12 the status byte. In the command byte, bit 0 marks end of packet, bit 1 asks for the frame check sequence and bit 3 asks for a status report. Registers are written through a select code: 0 sets base bits 31:0, 1 sets base bits 63:32, 2 sets the ring size in bytes, 3 sets the head and 4 sets the tail.

Top module: `tdr_fetcher`

## Requirements
- R1: After reset the head index is 0, the tail is 0, the ring holds 64 descriptors, and no memory or streamer request is raised.
- R2: When idle with head different from tail, the engine reads three 32-bit words of the head descriptor at base + 16*head + 0, +4 and +8, in that order. Descriptors are consumed in ring order.
- R3: For a nonzero length, a streamer request presents the 64-bit buffer address, the 16-bit length and the command byte. The request holds all three steady until it is acknowledged.
- R4: A descriptor whose length is zero is consumed without any streamer request.
- R5: When command bit 3 is set, the engine writes status byte 12 of the descriptor with value 0x01 (strobe 4'b0001). The write-back event output pulses for one cycle on the acknowledged write.
- R6: When command bit 3 is clear, no status write is made.
- R7: The head advances by one after each descriptor completes. It wraps to 0 when it reaches the ring size in bytes divided by 16.
- R8: A queue-empty event pulses once, in the cycle the head steps onto the tail.
- R9: A head write takes effect only while the engine is idle and is ignored while a descriptor is in progress.
- R10: With head equal to tail the engine makes no memory or streamer request.
- R11: A memory request keeps its address and direction stable until acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_sel_i | input | 3 | Register select code |
| reg_wdata_i | input | 32 | Register write data |
| head_o | output | 16 | Current head index |
| mem_req_o | output | 1 | Memory request |
| mem_we_o | output | 1 | Memory request is a write |
| mem_addr_o | output | 64 | Memory byte address |
| mem_wdata_o | output | 32 | Memory write data |
| mem_wstrb_o | output | 4 | Memory write byte strobes |
| mem_ack_i | input | 1 | Memory acknowledge; read data valid in the same cycle |
| mem_rdata_i | input | 32 | Memory read data |
| pkt_req_o | output | 1 | Streamer request |
| pkt_addr_o | output | 64 | Buffer address for the streamer |
| pkt_len_o | output | 16 | Buffer length in bytes |
| pkt_cmd_o | output | 8 | Descriptor command byte |
| pkt_ack_i | input | 1 | Streamer acknowledge |
| evt_wb_o | output | 1 | Status write-back pulse |
| evt_empty_o | output | 1 | Queue-empty pulse |

## Verification
A corrupted head or a bad wrap shows up on the very next descriptor fetch. The first read address then points at the wrong slot, and the bench compares every read address with its own ring walk. A lost command or length bit shows within a few cycles, either as a wrong streamer field or as a status write that should not be there. A miscounted completion leaves the head short of the tail, or puts the queue-empty pulse in the wrong place. Both are checked when each batch drains.

// File: rtl/tdr_pkg.sv
package tdr_pkg;
  localparam int ADDR_W     = 64;
  localparam int DESC_SHIFT = 4;   // 16-byte descriptors
  localparam int STS_OFFS   = 12;  // byte holding status

  localparam int CMD_EOP = 0;
  localparam int CMD_FCS = 1;
  localparam int CMD_RS  = 3;

  localparam logic [2:0] SEL_BASE_LO = 3'd0;
  localparam logic [2:0] SEL_BASE_HI = 3'd1;
  localparam logic [2:0] SEL_LEN     = 3'd2;
  localparam logic [2:0] SEL_HEAD    = 3'd3;
  localparam logic [2:0] SEL_TAIL    = 3'd4;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RD,
    ST_SEND,
    ST_WB,
    ST_ADV
  } tdr_state_e;
endpackage

// File: rtl/tdr_ring_regs.sv
module tdr_ring_regs
  import tdr_pkg::*;
#(
  parameter int LEN_W     = 20,
  parameter int DEF_DESCS = 64,
  localparam int IDX_W    = LEN_W - DESC_SHIFT
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic [2:0]        reg_sel_i,
  input  logic [31:0]       reg_wdata_i,
  input  logic              idle_i,
  input  logic              adv_i,
  output logic [ADDR_W-1:0] base_o,
  output logic [IDX_W-1:0]  head_o,
  output logic [IDX_W-1:0]  tail_o,
  output logic [IDX_W-1:0]  head_nxt_o,
  output logic              head_try_o
);
  localparam logic [LEN_W-1:0] LEN_RST = LEN_W'(DEF_DESCS << DESC_SHIFT);

  logic [63:0]      base_q;
  logic [LEN_W-1:0] len_q;
  logic [IDX_W-1:0] head_q, tail_q, num_desc;
  logic [IDX_W:0]   head_inc;
  logic             head_upd;

  assign num_desc   = len_q[LEN_W-1:DESC_SHIFT];
  assign head_inc   = {1'b0, head_q} + 1'b1;
  assign head_nxt_o = (head_inc >= {1'b0, num_desc}) ? '0 : head_inc[IDX_W-1:0];
  assign head_try_o = reg_we_i && (reg_sel_i == SEL_HEAD);
  assign head_upd   = head_try_o && idle_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_q <= '0;
      len_q  <= LEN_RST;
      head_q <= '0;
      tail_q <= '0;
    end else begin
      if (reg_we_i) begin
        case (reg_sel_i)
          SEL_BASE_LO: base_q[31:0]  <= reg_wdata_i;
          SEL_BASE_HI: base_q[63:32] <= reg_wdata_i;
          SEL_LEN:     len_q <= {reg_wdata_i[LEN_W-1:DESC_SHIFT], {DESC_SHIFT{1'b0}}};
          SEL_TAIL:    tail_q <= reg_wdata_i[IDX_W-1:0];
          default: ;
        endcase
      end
      if (head_upd)   head_q <= reg_wdata_i[IDX_W-1:0];
      else if (adv_i) head_q <= head_nxt_o;
    end
  end

  assign base_o = base_q[ADDR_W-1:0];
  assign head_o = head_q;
  assign tail_o = tail_q;

  // R9: busy head write leaves head alone (or on its normal step)
  a_r9_head_write_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    head_try_o && !idle_i |=> head_q == $past(head_q) || head_q == $past(head_nxt_o));
  // R7: head moves only on completion or an accepted write
  a_r7_head_moves_on_event: assert property (@(posedge clk_i) disable iff (!rst_ni)
    head_q != $past(head_q) |-> $past(adv_i) || $past(head_upd));
endmodule

// File: rtl/tdr_fetch_fsm.sv
module tdr_fetch_fsm
  import tdr_pkg::*;
#(
  parameter int IDX_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] base_i,
  input  logic [IDX_W-1:0]  head_i,
  input  logic [IDX_W-1:0]  tail_i,
  input  logic [IDX_W-1:0]  head_nxt_i,
  input  logic              head_try_i,
  output logic              idle_o,
  output logic              adv_o,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [31:0]       mem_wdata_o,
  output logic [3:0]        mem_wstrb_o,
  input  logic              mem_ack_i,
  input  logic [31:0]       mem_rdata_i,
  output logic              pkt_req_o,
  output logic [ADDR_W-1:0] pkt_addr_o,
  output logic [15:0]       pkt_len_o,
  output logic [7:0]        pkt_cmd_o,
  input  logic              pkt_ack_i,
  output logic              evt_wb_o,
  output logic              evt_empty_o
);
  tdr_state_e        state_q;
  logic [1:0]        wcnt_q;
  logic [63:0]       buf_q;
  logic [15:0]       len_q;
  logic [7:0]        cmd_q;
  logic [ADDR_W-1:0] desc_base;
  logic [15:0]       rd_len;
  logic [7:0]        rd_cmd;

  assign desc_base = base_i + (ADDR_W'(head_i) << DESC_SHIFT);
  assign rd_len    = mem_rdata_i[15:0];
  assign rd_cmd    = mem_rdata_i[31:24];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      wcnt_q  <= '0;
      buf_q   <= '0;
      len_q   <= '0;
      cmd_q   <= '0;
    end else begin
      case (state_q)
        ST_IDLE: if (head_i != tail_i && !head_try_i) begin
          state_q <= ST_RD;
          wcnt_q  <= '0;
        end
        ST_RD: if (mem_ack_i) begin
          wcnt_q <= wcnt_q + 1'b1;
          case (wcnt_q)
            2'd0: buf_q[31:0]  <= mem_rdata_i;
            2'd1: buf_q[63:32] <= mem_rdata_i;
            default: begin
              len_q <= rd_len;
              cmd_q <= rd_cmd;
              if (rd_len != '0)        state_q <= ST_SEND;
              else if (rd_cmd[CMD_RS]) state_q <= ST_WB;
              else                     state_q <= ST_ADV;
            end
          endcase
        end
        ST_SEND: if (pkt_ack_i) state_q <= cmd_q[CMD_RS] ? ST_WB : ST_ADV;
        ST_WB:   if (mem_ack_i) state_q <= ST_ADV;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign idle_o      = (state_q == ST_IDLE);
  assign adv_o       = (state_q == ST_ADV);
  assign mem_req_o   = (state_q == ST_RD) || (state_q == ST_WB);
  assign mem_we_o    = (state_q == ST_WB);
  assign mem_addr_o  = desc_base + (mem_we_o ? ADDR_W'(STS_OFFS) : ADDR_W'({wcnt_q, 2'b00}));
  assign mem_wdata_o = 32'h0000_0001;
  assign mem_wstrb_o = mem_we_o ? 4'b0001 : 4'b0000;
  assign pkt_req_o   = (state_q == ST_SEND);
  assign pkt_addr_o  = buf_q[ADDR_W-1:0];
  assign pkt_len_o   = len_q;
  assign pkt_cmd_o   = cmd_q;
  assign evt_wb_o    = mem_we_o && mem_ack_i;
  assign evt_empty_o = adv_o && (head_nxt_i == tail_i);

  // R11
  a_r11_mem_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && !mem_ack_i |=> mem_req_o && $stable(mem_addr_o) && $stable(mem_we_o));
  // R3
  a_r3_pkt_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pkt_req_o && !pkt_ack_i |=> pkt_req_o && $stable(pkt_addr_o) && $stable(pkt_len_o)
                                && $stable(pkt_cmd_o));
  // R4
  a_r4_no_zero_len: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pkt_req_o |-> pkt_len_o != '0);
  // R5 / R6
  a_r5_wb_only_on_rs: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && mem_we_o |-> cmd_q[CMD_RS] && mem_wstrb_o == 4'b0001 && mem_wdata_o[0]);
  // R8
  a_r8_empty_then_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_empty_o |=> idle_o && head_i == tail_i);
  // R10
  a_r10_quiet_when_empty: assert property (@(posedge clk_i) disable iff (!rst_ni)
    idle_o && head_i == tail_i |=> !mem_req_o && !pkt_req_o);
endmodule

// File: rtl/tdr_fetcher.sv
module tdr_fetcher
  import tdr_pkg::*;
#(
  parameter int LEN_W     = 20,
  parameter int DEF_DESCS = 64,
  localparam int IDX_W    = LEN_W - DESC_SHIFT
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic [2:0]        reg_sel_i,
  input  logic [31:0]       reg_wdata_i,
  output logic [IDX_W-1:0]  head_o,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [31:0]       mem_wdata_o,
  output logic [3:0]        mem_wstrb_o,
  input  logic              mem_ack_i,
  input  logic [31:0]       mem_rdata_i,
  output logic              pkt_req_o,
  output logic [ADDR_W-1:0] pkt_addr_o,
  output logic [15:0]       pkt_len_o,
  output logic [7:0]        pkt_cmd_o,
  input  logic              pkt_ack_i,
  output logic              evt_wb_o,
  output logic              evt_empty_o
);
  logic [ADDR_W-1:0] base;
  logic [IDX_W-1:0]  head, tail, head_nxt;
  logic              head_try, idle, adv;

  tdr_ring_regs #(.LEN_W(LEN_W), .DEF_DESCS(DEF_DESCS)) u_regs (
    .clk_i, .rst_ni, .reg_we_i, .reg_sel_i, .reg_wdata_i,
    .idle_i(idle), .adv_i(adv), .base_o(base), .head_o(head), .tail_o(tail),
    .head_nxt_o(head_nxt), .head_try_o(head_try)
  );

  tdr_fetch_fsm #(.IDX_W(IDX_W)) u_fsm (
    .clk_i, .rst_ni, .base_i(base), .head_i(head), .tail_i(tail),
    .head_nxt_i(head_nxt), .head_try_i(head_try), .idle_o(idle), .adv_o(adv),
    .mem_req_o, .mem_we_o, .mem_addr_o, .mem_wdata_o, .mem_wstrb_o,
    .mem_ack_i, .mem_rdata_i, .pkt_req_o, .pkt_addr_o, .pkt_len_o, .pkt_cmd_o,
    .pkt_ack_i, .evt_wb_o, .evt_empty_o
  );

  assign head_o = head;
endmodule

// File: tb/tdr_fetcher_tb.sv
module tdr_fetcher_tb;
  logic        clk = 1'b0, rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [2:0]  reg_sel = '0;
  logic [31:0] reg_wdata = '0;
  logic [15:0] head;
  logic        mem_req, mem_we, mem_ack = 1'b0;
  logic [63:0] mem_addr;
  logic [31:0] mem_wdata, mem_rdata = '0;
  logic [3:0]  mem_wstrb;
  logic        pkt_req, pkt_ack = 1'b0;
  logic [63:0] pkt_addr;
  logic [15:0] pkt_len;
  logic [7:0]  pkt_cmd;
  logic        evt_wb, evt_empty;

  always #2.5 clk = ~clk;

  tdr_fetcher u_dut (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(reg_we), .reg_sel_i(reg_sel),
    .reg_wdata_i(reg_wdata), .head_o(head), .mem_req_o(mem_req), .mem_we_o(mem_we),
    .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata), .mem_wstrb_o(mem_wstrb),
    .mem_ack_i(mem_ack), .mem_rdata_i(mem_rdata), .pkt_req_o(pkt_req),
    .pkt_addr_o(pkt_addr), .pkt_len_o(pkt_len), .pkt_cmd_o(pkt_cmd),
    .pkt_ack_i(pkt_ack), .evt_wb_o(evt_wb), .evt_empty_o(evt_empty)
  );

  localparam logic [63:0] BASE = 64'h0000_0012_3400_0000;

  logic [63:0] d_addr [64];
  logic [15:0] d_len  [64];
  logic [7:0]  d_cmd  [64];
  int nchk = 0, nfail = 0;
  int ring_n = 64, exp_fetch = 0, cur_idx = 0, word_n = 0;
  int n_fetch, n_pkt, n_wb, n_evwb, n_evempty, n_req;
  int e_n, e_nz, e_rs;
  bit done = 0;

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int nxt(input int i);
    return (i + 1 == ring_n) ? 0 : i + 1;
  endfunction

  task automatic clear_counts();
    n_fetch = 0; n_pkt = 0; n_wb = 0; n_evwb = 0; n_evempty = 0; n_req = 0;
  endtask

  task automatic reg_write(input logic [2:0] sel, input logic [31:0] val);
    @(negedge clk);
    reg_we = 1'b1; reg_sel = sel; reg_wdata = val;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic fill_ring();
    for (int i = 0; i < 64; i++) begin
      d_addr[i] = {$urandom, $urandom};
      d_len[i]  = ($urandom % 4 == 0) ? 16'd0 : 16'($urandom % 1600 + 1);
      d_cmd[i]  = 8'($urandom);
    end
    d_len[3] = 16'd0;  d_cmd[3][3] = 1'b1;   // zero length with status report
    d_len[2] = 16'd60; d_cmd[2][3] = 1'b1;
    d_cmd[5][3] = 1'b0;
  endtask

  task automatic expect_range(input int start, input int stop);
    e_n = 0; e_nz = 0; e_rs = 0;
    for (int i = start; i != stop; i = nxt(i)) begin
      e_n++;
      if (d_len[i] != 0) e_nz++;
      if (d_cmd[i][3]) e_rs++;
    end
  endtask

  task automatic batch_finish(input int stop);
    for (int k = 0; k < 20000 && n_evempty == 0; k++) @(negedge clk);
    repeat (4) @(negedge clk);
    chk("R2 descriptors fetched", 64'(n_fetch), 64'(e_n));
    chk("R4 streamer requests", 64'(n_pkt), 64'(e_nz));
    chk("R6 status writes", 64'(n_wb), 64'(e_rs));
    chk("R5 write-back pulses", 64'(n_evwb), 64'(e_rs));
    chk("R8 empty pulses", 64'(n_evempty), 64'd1);
    chk("R7 head reaches tail", 64'(head), 64'(stop));
  endtask

  task automatic batch(input int start, input int stop);
    expect_range(start, stop);
    clear_counts();
    exp_fetch = start;
    reg_write(3'd4, 32'(stop));
    batch_finish(stop);
  endtask

  // memory and streamer responder
  initial begin
    logic [63:0] off;
    int idx, w;
    forever begin
      @(negedge clk);
      mem_ack = 1'b0; pkt_ack = 1'b0;
      if (mem_req) n_req++;
      if (rst_n && mem_req && ($urandom % 3 != 0)) begin
        mem_ack = 1'b1;
        off = mem_addr - BASE;
        idx = int'(off[9:4]); w = int'(off[3:2]);
        if (mem_we) begin
          n_wb++;
          chk("R5 status address", off, 64'(cur_idx * 16 + 12));
          chk("R5 status strobe", 64'(mem_wstrb), 64'h1);
          chk("R5 status done bit", 64'(mem_wdata[7:0]), 64'h1);
          chk("R6 status only with report bit", 64'(d_cmd[cur_idx][3]), 64'h1);
        end else begin
          chk("R2 read address", off, 64'(exp_fetch * 16 + word_n * 4));
          case (w)
            0:       mem_rdata = d_addr[idx][31:0];
            1:       mem_rdata = d_addr[idx][63:32];
            default: mem_rdata = {d_cmd[idx], 8'h5a, d_len[idx]};
          endcase
          if (word_n == 2) begin
            cur_idx = exp_fetch; exp_fetch = nxt(exp_fetch); word_n = 0; n_fetch++;
          end else word_n++;
        end
      end
      if (rst_n && pkt_req && ($urandom % 2 == 0)) begin
        pkt_ack = 1'b1;
        n_pkt++;
        chk("R3 buffer address", pkt_addr, d_addr[cur_idx]);
        chk("R3 buffer length", 64'(pkt_len), 64'(d_len[cur_idx]));
        chk("R3 command byte", 64'(pkt_cmd), 64'(d_cmd[cur_idx]));
      end
      #1;
      if (evt_wb) n_evwb++;
      if (evt_empty) n_evempty++;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nfail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd7));
    clear_counts();
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 head at reset", 64'(head), 64'd0);
    chk("R1 no memory request", 64'(mem_req), 64'd0);
    chk("R1 no streamer request", 64'(pkt_req), 64'd0);
    rst_n = 1'b1;
    reg_write(3'd0, BASE[31:0]);
    reg_write(3'd1, BASE[63:32]);
    // R10 empty ring stays quiet
    clear_counts();
    repeat (20) @(negedge clk);
    chk("R10 no request on empty ring", 64'(n_req + n_pkt), 64'd0);

    fill_ring();
    batch(0, 10);

    // R9 head write while busy is ignored
    expect_range(10, 20);
    clear_counts();
    exp_fetch = 10;
    reg_write(3'd4, 32'd20);
    reg_write(3'd3, 32'd5);
    chk("R9 busy head write ignored", 64'(head), 64'd10);
    batch_finish(20);

    // R9 idle head write accepted; R7 wrap at 64 (R1 default size)
    fill_ring();
    expect_range(56, 20);
    clear_counts();
    exp_fetch = 56;
    reg_write(3'd3, 32'd56);
    chk("R9 idle head write", 64'(head), 64'd56);
    batch_finish(20);

    fill_ring();
    batch(20, 4);

    // R7 wrap on a ring of 8 descriptors
    reg_write(3'd2, 32'd128);
    ring_n = 8;
    fill_ring();
    batch(4, 1);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule